// File: doc/BRIEF.md
# Burst Write Master Sequencer with Latency-Timer Termination

This block runs the control half of a PCI-style burst write as bus master. It drives the active-low FRAME# and IRDY# strobes. It watches the target's active-low TRDY# and the arbiter's active-low GNT#. On the local side it takes a start request with a word count, a latency-timer preload and a data-ready strobe. It pulses an acknowledge for every word the target accepts.

A burst opens with one address cycle. Data phases follow, one per word. The master marks the final phase by releasing FRAME# in the same clock that it drives IRDY#. The target may hold TRDY# deasserted to insert wait states. While a phase is pending, FRAME# and IRDY# are frozen.

A latency timer runs during the burst. When it has run out and the grant has been withdrawn, the burst is cut short. The cut never moves FRAME# during a pending phase. The block waits until the next IRDY# assertion and makes that phase the last one. The running word count stays on an output, so the local side can ask again for the words that were not sent.

Top module: `burst_master_seq`

## Requirements
- R1: While reset is held, and directly after it, `frame_n_o` and `irdy_n_o` are 1, `busy_o` is 0 and `words_done_o` is 0.
- R2: A start is taken at a rising edge where `start_i`=1, `gnt_n_i`=0 and `len_i`≠0, and the block is idle or in its turnaround cycle. The next cycle is the address cycle, with `frame_n_o`=0 and `irdy_n_o`=1.
- R3: FRAME# changes from 0 to 1 only in a cycle in which `irdy_n_o` is 0. A burst of one word shows `frame_n_o`=1 and `irdy_n_o`=0 in the cycle after its address cycle.
- R4: A phase completes at a rising edge where `irdy_n_o`=0 and `trdy_n_i`=0. If `frame_n_o` was 1 at that phase, both strobes are 1 in the following cycle.
- R5: While a phase is pending (`irdy_n_o`=0, `trdy_n_i`=1), `frame_n_o` keeps its value into the next cycle.
- R6: During a wait state, `irdy_n_o` stays 0 into the next cycle.
- R7: The latency timer holds `lat_cfg_i` in the address cycle. It drops by one in each later cycle with FRAME# asserted and stops at 0. When the timer is 0 and `gnt_n_i`=1 in a cycle, the cut is recorded. The next phase launched in or after that cycle is the last one.
- R8: If the timer reaches 0 while `gnt_n_i` stays 0, the burst runs for the full `len_i` words.
- R9: A cut recorded while a phase is pending lets that phase complete with FRAME# asserted. Exactly one more phase follows, and it is the last.
- R10: After the last phase completes, both strobes stay 1 for exactly one cycle. A start held high is then taken, so the next address cycle follows that single idle cycle.
- R11: `word_ack_o` is 1 in each cycle that ends with a completing phase. `words_done_o` is cleared when a start is taken, rises by one per completion, and holds after the burst ends.
- R12: A start request with `gnt_n_i`=1 or with `len_i`=0 is ignored, and `frame_n_o` and `busy_o` stay idle.
- R13: In a cycle where `data_rdy_i`=0 and no phase is pending, no phase is launched. `irdy_n_o` is 1 and `frame_n_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to open a burst |
| len_i | input | LEN_W | Words in the requested burst, sampled at start |
| lat_cfg_i | input | LAT_W | Latency-timer preload, sampled at start |
| data_rdy_i | input | 1 | Local data for the next word is available |
| gnt_n_i | input | 1 | Bus grant, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| frame_n_o | output | 1 | FRAME#, active low |
| irdy_n_o | output | 1 | IRDY#, active low |
| word_ack_o | output | 1 | Pulse: a data phase completes at the coming edge |
| words_done_o | output | LEN_W | Words completed in the current or last burst |
| busy_o | output | 1 | A burst or its turnaround cycle is in progress |

## Verification
The assertions assume that `len_i` and `lat_cfg_i` matter only at the edge where a start is taken. They also assume that TRDY# is looked at only while IRDY# is asserted, and that the target never pulls it low outside a data phase. The bench's target model keeps to this. It drives TRDY# only after seeing IRDY# asserted, and only after the number of wait states chosen for each case. Grant and local inputs change only half a cycle away from the sampling edge, so every cut lands in a known cycle of the timer count.

// File: rtl/burst_master_seq.sv
module burst_master_seq #(
  parameter int LEN_W = 8,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LAT_W-1:0] lat_cfg_i,
  input  logic             data_rdy_i,
  input  logic             gnt_n_i,
  input  logic             trdy_n_i,
  output logic             frame_n_o,
  output logic             irdy_n_o,
  output logic             word_ack_o,
  output logic [LEN_W-1:0] words_done_o,
  output logic             busy_o
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_TURN} st_t;

  st_t              st;
  logic             frame_q, irdy_q, cut_q;
  logic [LEN_W-1:0] left_q, cnt_q, left_after;
  logic [LAT_W-1:0] lat_q;
  logic             go, cut_any, done_ph, next_last, launch;

  assign go         = start_i && !gnt_n_i && (len_i != '0);
  assign cut_any    = cut_q || (frame_q && (lat_q == '0) && gnt_n_i);
  assign done_ph    = irdy_q && !trdy_n_i;
  assign left_after = done_ph ? left_q - 1'b1 : left_q;
  assign next_last  = (left_after == LEN_W'(1)) || cut_any;
  assign launch     = data_rdy_i && frame_q &&
                      ((st == S_ADDR) || (st == S_DATA && (!irdy_q || done_ph)));

  assign frame_n_o    = !frame_q;
  assign irdy_n_o     = !irdy_q;
  assign word_ack_o   = done_ph;
  assign words_done_o = cnt_q;
  assign busy_o       = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b0;
      irdy_q  <= 1'b0;
      cut_q   <= 1'b0;
      left_q  <= '0;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else begin
      case (st)
        S_IDLE, S_TURN: begin
          if (go) begin
            st      <= S_ADDR;
            frame_q <= 1'b1;
            left_q  <= len_i;
            cnt_q   <= '0;
            lat_q   <= lat_cfg_i;
            cut_q   <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: begin
          if (frame_q && lat_q != '0) lat_q <= lat_q - 1'b1;
          if (frame_q) cut_q <= cut_any;
          if (done_ph) begin
            cnt_q  <= cnt_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
          if (done_ph && !frame_q) begin
            irdy_q <= 1'b0;
            st     <= S_TURN;
          end else if (launch) begin
            irdy_q  <= 1'b1;
            frame_q <= !next_last;
            st      <= S_DATA;
          end else if (done_ph) begin
            irdy_q <= 1'b0;
          end else if (st == S_ADDR) begin
            st <= S_DATA;
          end
        end
      endcase
    end
  end

  p_frame_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && trdy_n_i) |=> $stable(frame_n_o));

  p_irdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && trdy_n_i) |=> !irdy_n_o);

  p_frame_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n_o) |-> !irdy_n_o);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && !trdy_n_i && frame_n_o) |=> (irdy_n_o && frame_n_o));

  p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ack_o && busy_o) |=> (words_done_o == $past(words_done_o) + 1'b1));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && gnt_n_i) |=> (frame_n_o && !busy_o));

  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !gnt_n_i && len_i != '0) |=> (!frame_n_o && irdy_n_o));

endmodule

// File: tb/burst_master_seq_bench.sv
module burst_master_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic [7:0] lat_cfg_i = '0;
  logic       data_rdy_i = 1'b1;
  logic       gnt_n_i = 1'b0;
  logic       trdy_n_i = 1'b1;
  logic       frame_n_o, irdy_n_o, word_ack_o, busy_o;
  logic [7:0] words_done_o;

  always #2 clk = ~clk;

  burst_master_seq u_burst_master_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .lat_cfg_i(lat_cfg_i), .data_rdy_i(data_rdy_i), .gnt_n_i(gnt_n_i),
    .trdy_n_i(trdy_n_i), .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
    .word_ack_o(word_ack_o), .words_done_o(words_done_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0;
  int w_cfg = 0;
  int mon_words = 0, mon_last = 0, frm_bad = 0, irdy_bad = 0, rise_bad = 0, rel_bad = 0;

  // len, lat preload, drop grant after start, waits per phase, expected words
  localparam logic [39:0] VECS [0:9] = '{
    {8'd1, 8'd8,  8'd0, 8'd0, 8'd1},
    {8'd4, 8'd8,  8'd0, 8'd0, 8'd4},
    {8'd4, 8'd2,  8'd0, 8'd1, 8'd4},
    {8'd8, 8'd3,  8'd1, 8'd0, 8'd4},
    {8'd8, 8'd3,  8'd1, 8'd2, 8'd2},
    {8'd8, 8'd0,  8'd1, 8'd0, 8'd1},
    {8'd3, 8'd10, 8'd1, 8'd0, 8'd3},
    {8'd6, 8'd4,  8'd1, 8'd1, 8'd3},
    {8'd5, 8'd5,  8'd0, 8'd3, 8'd5},
    {8'd8, 8'd2,  8'd1, 8'd2, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clr_mon();
    mon_words = 0; mon_last = 0; frm_bad = 0; irdy_bad = 0; rise_bad = 0; rel_bad = 0;
  endtask

  // target model and protocol monitor, acting at the falling edge
  initial begin
    logic p_irdy = 1'b1, p_trdy = 1'b1, p_frame = 1'b1;
    int wc = 0;
    forever begin
      @(negedge clk);
      if (!p_irdy && !p_trdy) begin
        mon_words++;
        if (p_frame) begin
          mon_last = 1;
          if (!(irdy_n_o && frame_n_o)) rel_bad++;
        end
      end
      if (!p_irdy && p_trdy) begin
        if (frame_n_o !== p_frame) frm_bad++;
        if (irdy_n_o) irdy_bad++;
      end
      if (!p_frame && frame_n_o && irdy_n_o) rise_bad++;
      if (irdy_n_o) begin
        wc = 0; trdy_n_i = 1'b1;
      end else begin
        if (!trdy_n_i) wc = 0;
        if (wc == w_cfg) trdy_n_i = 1'b0;
        else begin trdy_n_i = 1'b1; wc++; end
      end
      p_irdy = irdy_n_o; p_trdy = trdy_n_i; p_frame = frame_n_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_vec(input int len, input int lat, input int drop, input int w, input int exp);
    w_cfg = w;
    while (busy_o) tick();
    clr_mon();
    len_i = 8'(len); lat_cfg_i = 8'(lat); gnt_n_i = 1'b0; data_rdy_i = 1'b1; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    gnt_n_i = drop[0];
    while (!mon_last) tick();
    chk(mon_words == exp, (drop != 0) ? "R7/R9 words on bus" : "R8 words on bus", mon_words, exp);
    chk(words_done_o == 8'(exp), "R11 words_done", int'(words_done_o), exp);
    chk(frm_bad == 0, "R5 frame held while pending", frm_bad, 0);
    chk(irdy_bad == 0, "R6 irdy held in wait", irdy_bad, 0);
    chk(rise_bad == 0, "R3 frame release with irdy", rise_bad, 0);
    chk(rel_bad == 0, "R4 release after last", rel_bad, 0);
    gnt_n_i = 1'b0;
    tick(); tick();
  endtask

  initial begin
    tick(); tick();
    chk(frame_n_o && irdy_n_o && !busy_o && words_done_o == 0, "R1 reset state",
        {frame_n_o, irdy_n_o, busy_o}, 3'b110);
    rst_n = 1'b1;
    tick();
    chk(frame_n_o && irdy_n_o && !busy_o, "R1 after reset", {frame_n_o, irdy_n_o, busy_o}, 3'b110);

    // R12: no grant, then zero length
    gnt_n_i = 1'b1; len_i = 8'd3; start_i = 1'b1;
    tick(); tick(); tick();
    chk(frame_n_o && !busy_o, "R12 start without grant", {frame_n_o, busy_o}, 2'b10);
    gnt_n_i = 1'b0; len_i = 8'd0;
    tick(); tick(); tick();
    chk(frame_n_o && !busy_o, "R12 start with zero length", {frame_n_o, busy_o}, 2'b10);
    start_i = 1'b0;
    tick();

    for (int i = 0; i < 10; i++)
      run_vec(int'(VECS[i][39:32]), int'(VECS[i][31:24]), int'(VECS[i][23:16]),
              int'(VECS[i][15:8]), int'(VECS[i][7:0]));

    // R2, R13, R3: data gap before the first phase
    w_cfg = 0; clr_mon();
    len_i = 8'd2; lat_cfg_i = 8'd200; data_rdy_i = 1'b0; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(!frame_n_o && irdy_n_o, "R2 address cycle", {frame_n_o, irdy_n_o}, 2'b01);
    tick();
    chk(!frame_n_o && irdy_n_o, "R13 no data, no phase", {frame_n_o, irdy_n_o}, 2'b01);
    data_rdy_i = 1'b1;
    tick();
    chk(!frame_n_o && !irdy_n_o, "R13 phase launched when data ready", {frame_n_o, irdy_n_o}, 2'b00);
    tick();
    chk(frame_n_o && !irdy_n_o, "R3 last phase of two", {frame_n_o, irdy_n_o}, 2'b10);
    while (!mon_last) tick();
    chk(mon_words == 2, "R11 gap burst words", mon_words, 2);
    tick(); tick();

    // R3: length one, R10: restart after one idle cycle
    clr_mon();
    len_i = 8'd1; lat_cfg_i = 8'd50; start_i = 1'b1;
    tick();
    chk(!frame_n_o && irdy_n_o, "R2 address cycle len1", {frame_n_o, irdy_n_o}, 2'b01);
    tick();
    chk(frame_n_o && !irdy_n_o, "R3 single word last at once", {frame_n_o, irdy_n_o}, 2'b10);
    while (!mon_last) tick();
    chk(frame_n_o && irdy_n_o, "R10 idle turnaround cycle", {frame_n_o, irdy_n_o}, 2'b11);
    tick();
    chk(!frame_n_o && irdy_n_o, "R10 restart after one idle", {frame_n_o, irdy_n_o}, 2'b01);
    start_i = 1'b0; mon_last = 0;
    while (!mon_last) tick();
    chk(words_done_o == 8'd1, "R11 count cleared on restart", int'(words_done_o), 1);
    tick(); tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule